// File: doc/BRIEF.md
# DMA Request Arbitration Sequencer

This block takes single-item and burst request lines from several channels and selects one channel. It then drives a run of item moves into a simple copy data path. Each move carries one item from a source pointer to a destination pointer. Every channel keeps its own settings: source and destination pointers, a remaining-item count, an item size, an arbitration exponent, flags that hold either pointer fixed, a flag that accepts burst requests only, and an enable bit. All of these are loaded through a register write port. The block decides how many items each grant moves and when the next grant may be chosen.

The copy data path receives one item at a time on a valid/ready interface. The block raises `xfer_valid` with the channel, pointers and size of the item. These outputs stay unchanged until the data path raises `xfer_ready`, and the item counts as moved only on the cycle where both are high. The data path may hold `xfer_ready` low for as long as it likes. The block only waits, and no state advances. `xfer_last` marks the final item of the current grant.

A configuration write aimed at the channel that holds the grant is dropped. Software arms a channel while it is idle.

Top module: `dma_req_seq`

## Requirements
- R1: A grant taken on a single request alone moves exactly one item. `xfer_valid` then stays low for at least one cycle before any next grant.
- R2: A grant taken on a burst request moves min(2^e, remaining count) items. Here e is the 4-bit exponent in CTRL bits [11:8], and any value above 10 is treated as 10.
- R3: When a channel's single and burst lines are both high, the grant is handled as a burst (R2 length).
- R4: Once a grant has started, `xfer_chan` does not change and no other channel is served until the grant's last item is accepted. This holds even when a lower-numbered channel requests in the meantime, or when the granting request line drops.
- R5: When CTRL bit 1 (burst-only) is set, the channel's single requests never start a grant, but its burst requests still do.
- R6: When the block is idle, the lowest-numbered qualified channel wins. A channel is qualified when it is enabled, its count is non-zero, and its burst line is high, or its single line is high and burst-only is clear.
- R7: Each accepted item decrements the channel's count. It also advances the source and destination pointers by 2^s bytes, where s is CTRL bits [5:4]. A pointer does not advance when its fixed flag is set: CTRL bit 2 for the source, CTRL bit 3 for the destination.
- R8: When the count reaches zero on an accepted item, the channel's enable bit (CTRL bit 0) clears. `ch_done` for that channel pulses high for exactly one cycle, in the cycle after the acceptance. Later requests on that channel are ignored until software re-arms it.
- R9: A channel whose enable bit is clear, or whose count is zero, is never granted, whatever its request lines do.
- R10: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_chan`, `xfer_src`, `xfer_dst`, `xfer_size` and `xfer_last` hold their values.

Write port: `cfg_sel` 0 loads the source pointer, 1 the destination pointer, 2 the count (low CW bits), 3 CTRL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sreq | input | NCH | Per-channel single-item request lines |
| breq | input | NCH | Per-channel burst request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Field select: 0 src, 1 dst, 2 count, 3 CTRL |
| cfg_wdata | input | AW | Write data |
| xfer_valid | output | 1 | An item move is offered |
| xfer_ready | input | 1 | Data path accepts the offered item |
| xfer_chan | output | CHW | Channel owning the offered item |
| xfer_src | output | AW | Source byte address of the item |
| xfer_dst | output | AW | Destination byte address of the item |
| xfer_size | output | 2 | log2 of the item size in bytes |
| xfer_last | output | 1 | Offered item is the last of this grant |
| ch_done | output | NCH | One-cycle completion pulse per channel |

## Verification
A corrupted burst counter makes a grant too long or too short. This shows at `xfer_last` on the item where the lengths first differ, and as a wrong gap once the grant ends. A count or pointer register that goes wrong shows at `xfer_src` or `xfer_dst` on that channel's next offered item. It can also show as a `ch_done` pulse that comes early, late or never. A stale enable bit, or a faulty qualification, shows as a grant one cycle after an ignored request, or as a missing grant in that cycle. The bench keeps a cycle-exact model and compares every offered item and every cycle of `ch_done`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // configuration field selects
  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // CTRL bit positions
  localparam int CB_EN     = 0;
  localparam int CB_BONLY  = 1;
  localparam int CB_SFIX   = 2;
  localparam int CB_DFIX   = 3;
  localparam int CB_SZ_LO  = 4;
  localparam int CB_EXP_LO = 8;

  localparam int ARB_EXP_MAX = 10;

endpackage

// File: rtl/dma_seq_chregs.sv
module dma_seq_chregs
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CHW-1:0]          cfg_ch,
  input  logic [1:0]              cfg_sel,
  input  logic [AW-1:0]           cfg_wdata,
  input  logic                    lock,
  input  logic [CHW-1:0]          lock_ch,
  input  logic                    step,
  input  logic [CHW-1:0]          step_ch,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          bonly_o,
  output logic [NCH-1:0][AW-1:0]  src_o,
  output logic [NCH-1:0][AW-1:0]  dst_o,
  output logic [NCH-1:0][CW-1:0]  cnt_o,
  output logic [NCH-1:0][3:0]     exp_o,
  output logic [NCH-1:0][1:0]     size_o,
  output logic [NCH-1:0]          done_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] src_q, dst_q, inc;
    logic [CW-1:0] cnt_q;
    logic          en_q, bo_q, sf_q, df_q, dn_q;
    logic [1:0]    sz_q;
    logic [3:0]    ex_q;
    logic          hit_step, hit_cfg;

    assign hit_step = step && (step_ch == CHW'(g));
    assign hit_cfg  = cfg_we && (cfg_ch == CHW'(g)) && !(lock && (lock_ch == CHW'(g)));
    assign inc      = AW'(1) << sz_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q <= '0;
        dst_q <= '0;
        cnt_q <= '0;
        en_q  <= 1'b0;
        bo_q  <= 1'b0;
        sf_q  <= 1'b0;
        df_q  <= 1'b0;
        sz_q  <= '0;
        ex_q  <= '0;
        dn_q  <= 1'b0;
      end else begin
        dn_q <= hit_step && (cnt_q == CW'(1));
        if (hit_step) begin
          cnt_q <= cnt_q - CW'(1);
          if (!sf_q) src_q <= src_q + inc;
          if (!df_q) dst_q <= dst_q + inc;
          if (cnt_q == CW'(1)) en_q <= 1'b0;
        end else if (hit_cfg) begin
          unique case (cfg_sel)
            SEL_SRC: src_q <= cfg_wdata;
            SEL_DST: dst_q <= cfg_wdata;
            SEL_CNT: cnt_q <= cfg_wdata[CW-1:0];
            default: begin
              en_q <= cfg_wdata[CB_EN];
              bo_q <= cfg_wdata[CB_BONLY];
              sf_q <= cfg_wdata[CB_SFIX];
              df_q <= cfg_wdata[CB_DFIX];
              sz_q <= cfg_wdata[CB_SZ_LO +: 2];
              ex_q <= cfg_wdata[CB_EXP_LO +: 4];
            end
          endcase
        end
      end
    end

    assign en_o[g]    = en_q;
    assign bonly_o[g] = bo_q;
    assign src_o[g]   = src_q;
    assign dst_o[g]   = dst_q;
    assign cnt_o[g]   = cnt_q;
    assign exp_o[g]   = ex_q;
    assign size_o[g]  = sz_q;
    assign done_o[g]  = dn_q;

    // R8: a completion pulse always leaves the channel disarmed
    p_done_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_q |-> !en_q);

    // R7: a step never lands on an exhausted count
    p_step_has_items_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_step |-> (cnt_q != '0));
  end

  // R8: at most one channel completes per cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

endmodule

// File: rtl/dma_seq_qual.sv
module dma_seq_qual #(
  parameter int NCH = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sreq,
  input  logic [NCH-1:0] breq,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] bonly,
  input  logic [NCH-1:0] cnt_nz,
  output logic           win_any,
  output logic [CHW-1:0] win_ch,
  output logic           win_burst
);

  logic [NCH-1:0] cand;

  assign cand = en & cnt_nz & (breq | (sreq & ~bonly));

  always_comb begin
    win_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) win_ch = CHW'(i);
    end
  end

  assign win_any   = |cand;
  assign win_burst = breq[win_ch];

  // R5: a burst-only winner was selected by its burst line
  p_bonly_needs_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && bonly[win_ch]) |-> breq[win_ch]);

  // R9: a winner is always armed and has items left
  p_winner_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> (en[win_ch] && cnt_nz[win_ch]));

endmodule

// File: rtl/dma_seq_xfer.sv
module dma_seq_xfer
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_any,
  input  logic [CHW-1:0] win_ch,
  input  logic           win_burst,
  input  logic [CW-1:0]  win_cnt,
  input  logic [3:0]     win_exp,
  input  logic           xfer_ready,
  output logic           xfer_valid,
  output logic [CHW-1:0] cur_ch,
  output logic           last,
  output logic           step
);

  seq_state_e    state_q;
  logic [CW-1:0] left_q;
  logic [3:0]    exp_c;
  logic [CW-1:0] arb_items, grant_len;

  assign exp_c     = (win_exp > 4'(ARB_EXP_MAX)) ? 4'(ARB_EXP_MAX) : win_exp;
  assign arb_items = CW'(1) << exp_c;
  assign grant_len = win_burst ? ((arb_items < win_cnt) ? arb_items : win_cnt) : CW'(1);

  assign xfer_valid = (state_q == SEQ_RUN);
  assign last       = (left_q == CW'(1));
  assign step       = xfer_valid && xfer_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
      cur_ch  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (win_any) begin
            state_q <= SEQ_RUN;
            cur_ch  <= win_ch;
            left_q  <= grant_len;
          end
        end
        default: begin
          if (step) begin
            left_q <= left_q - CW'(1);
            if (last) state_q <= SEQ_IDLE;
          end
        end
      endcase
    end
  end

  // R10: an offered item is held until accepted
  p_hold_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(cur_ch) && $stable(left_q)));

  // R4: a running grant keeps its channel until its last item
  p_no_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !(step && last)) |=> (xfer_valid && $stable(cur_ch)));

  // R1: the end of every grant leaves one idle cycle
  p_gap_after_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> !xfer_valid);

  // R2: an active grant never has zero items outstanding
  p_left_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (left_q != '0));

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sreq,
  input  logic [NCH-1:0] breq,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic           xfer_valid,
  input  logic           xfer_ready,
  output logic [CHW-1:0] xfer_chan,
  output logic [AW-1:0]  xfer_src,
  output logic [AW-1:0]  xfer_dst,
  output logic [1:0]     xfer_size,
  output logic           xfer_last,
  output logic [NCH-1:0] ch_done
);

  logic [NCH-1:0]         en, bonly, cnt_nz;
  logic [NCH-1:0][AW-1:0] src, dst;
  logic [NCH-1:0][CW-1:0] cnt;
  logic [NCH-1:0][3:0]    exps;
  logic [NCH-1:0][1:0]    sizes;
  logic                   win_any, win_burst, step;
  logic [CHW-1:0]         win_ch, cur_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_nz
    assign cnt_nz[g] = (cnt[g] != '0);
  end

  dma_seq_chregs #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_ch   (cfg_ch),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .lock     (xfer_valid),
    .lock_ch  (cur_ch),
    .step     (step),
    .step_ch  (cur_ch),
    .en_o     (en),
    .bonly_o  (bonly),
    .src_o    (src),
    .dst_o    (dst),
    .cnt_o    (cnt),
    .exp_o    (exps),
    .size_o   (sizes),
    .done_o   (ch_done)
  );

  dma_seq_qual #(.NCH(NCH), .CHW(CHW)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .sreq     (sreq),
    .breq     (breq),
    .en       (en),
    .bonly    (bonly),
    .cnt_nz   (cnt_nz),
    .win_any  (win_any),
    .win_ch   (win_ch),
    .win_burst(win_burst)
  );

  dma_seq_xfer #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_any   (win_any),
    .win_ch    (win_ch),
    .win_burst (win_burst),
    .win_cnt   (cnt[win_ch]),
    .win_exp   (exps[win_ch]),
    .xfer_ready(xfer_ready),
    .xfer_valid(xfer_valid),
    .cur_ch    (cur_ch),
    .last      (xfer_last),
    .step      (step)
  );

  assign xfer_chan = cur_ch;
  assign xfer_src  = src[cur_ch];
  assign xfer_dst  = dst[cur_ch];
  assign xfer_size = sizes[cur_ch];

  // R9: only armed channels with items left are ever offered
  p_offer_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (en[cur_ch] && cnt_nz[cur_ch]));

  // R10: pointers of a stalled offer do not move
  p_stall_ptrs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> ($stable(xfer_src) && $stable(xfer_dst)));

  // R7: an accepted item on a non-fixed source advances it by the item size
  p_src_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !xfer_last) |=> (xfer_src == $past(xfer_src) + (AW'(1) << $past(xfer_size))) || $stable(xfer_src));

endmodule

// File: tb/sim_dma_req_seq.sv
`timescale 1ns/100ps
module sim_dma_req_seq;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CW  = 16;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] sreq = '0, breq = '0;
  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic           xfer_valid, xfer_ready = 1'b0, xfer_last;
  logic [CHW-1:0] xfer_chan;
  logic [AW-1:0]  xfer_src, xfer_dst;
  logic [1:0]     xfer_size;
  logic [NCH-1:0] ch_done;

  always #2.5 clk = ~clk;

  dma_req_seq #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u0 (
    .clk(clk), .rst_n(rst_n), .sreq(sreq), .breq(breq),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_chan(xfer_chan),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_size(xfer_size),
    .xfer_last(xfer_last), .ch_done(ch_done)
  );

  int total = 0, bad = 0;
  int rdy_pct = 100;
  int cycles = 0;
  bit finished = 0;

  // reference model
  bit          m_en[NCH], m_bo[NCH], m_sf[NCH], m_df[NCH];
  int          m_cnt[NCH], m_exp[NCH], m_sz[NCH];
  logic [31:0] m_src[NCH], m_dst[NCH];
  bit          m_run = 0, gap = 1;
  int          m_ch = 0, m_left = 0;
  string       m_tag = "R1";
  logic [NCH-1:0] s_prev = '0, b_prev = '0, done_exp = '0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(logic [NCH-1:0] s, logic [NCH-1:0] b);
    for (int i = 0; i < NCH; i++)
      if (m_en[i] && m_cnt[i] != 0 && (b[i] || (s[i] && !m_bo[i]))) return i;
    return -1;
  endfunction

  function automatic int glen(int ch, bit burst);
    int e, a;
    if (!burst) return 1;
    e = (m_exp[ch] > 10) ? 10 : m_exp[ch];
    a = 1 << e;
    return (a < m_cnt[ch]) ? a : m_cnt[ch];
  endfunction

  // cycle monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      m_run = 0; gap = 1; done_exp = '0; s_prev = '0; b_prev = '0;
    end else begin
      int p;
      if (done_exp != '0 || ch_done != '0)
        chk(ch_done == done_exp, "R8", "ch_done", ch_done, done_exp);
      done_exp = '0;
      if (!m_run) begin
        if (gap) begin
          if (xfer_valid) chk(0, "R1", "valid in idle gap", 1, 0);
          gap = 0;
        end else begin
          p = pick(s_prev, b_prev);
          if (p >= 0) begin
            chk(xfer_valid, "R6", "grant expected", xfer_valid, 1);
            if (xfer_valid) begin
              chk(xfer_chan == p, "R6", "granted channel", xfer_chan, p);
              m_run = 1; m_ch = p;
              m_left = glen(p, b_prev[p]);
              m_tag = b_prev[p] ? (s_prev[p] ? "R3" : "R2") : "R1";
            end
          end else if (xfer_valid) begin
            chk(0, "R9", "grant with no qualified channel (R5 also)", xfer_chan, -1);
          end
        end
      end
      if (m_run) begin
        if (!xfer_valid) begin
          chk(0, "R10", "valid dropped inside grant", 0, 1);
          m_run = 0;
        end else begin
          chk(xfer_chan == m_ch, "R4", "channel inside grant", xfer_chan, m_ch);
          chk(xfer_src == m_src[m_ch], "R7", "src pointer", xfer_src, m_src[m_ch]);
          chk(xfer_dst == m_dst[m_ch], "R7", "dst pointer", xfer_dst, m_dst[m_ch]);
          chk(xfer_size == m_sz[m_ch], "R7", "item size", xfer_size, m_sz[m_ch]);
          chk(xfer_last == (m_left == 1), m_tag, "last flag / grant length", xfer_last, m_left == 1);
          if (xfer_ready) begin
            m_cnt[m_ch]--;
            if (!m_sf[m_ch]) m_src[m_ch] += 32'(1) << m_sz[m_ch];
            if (!m_df[m_ch]) m_dst[m_ch] += 32'(1) << m_sz[m_ch];
            if (m_cnt[m_ch] == 0) begin
              m_en[m_ch] = 0;
              done_exp[m_ch] = 1'b1;
            end
            m_left--;
            if (m_left == 0) begin
              m_run = 0; gap = 1;
            end
          end
        end
      end
      s_prev = sreq; b_prev = breq;
    end
  end

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      xfer_ready = (($urandom % 100) < rdy_pct);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R10 watchdog cycles=%0d expected<%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int ch, logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic arm(int ch, bit en, bit bo, bit sf, bit df, int sz, int ex, int cnt,
                     logic [31:0] s, logic [31:0] d);
    wr(ch, 2'd0, s);
    wr(ch, 2'd1, d);
    wr(ch, 2'd2, 32'(cnt));
    wr(ch, 2'd3, {20'd0, 4'(ex), 2'd0, 2'(sz), df, sf, bo, en});
    m_en[ch] = en; m_bo[ch] = bo; m_sf[ch] = sf; m_df[ch] = df;
    m_sz[ch] = sz; m_exp[ch] = ex; m_cnt[ch] = cnt & 16'hFFFF;
    m_src[ch] = s; m_dst[ch] = d;
  endtask

  task automatic req(logic [NCH-1:0] s, logic [NCH-1:0] b, int hold);
    @(posedge clk); #1;
    sreq = s; breq = b;
    repeat (hold) @(posedge clk);
    #1;
    sreq = '0; breq = '0;
  endtask

  task automatic wait_idle();
    int n = 0, t = 0;
    while (n < 3) begin
      @(negedge clk);
      t++;
      if (!m_run && !xfer_valid && sreq == '0 && breq == '0) n++; else n = 0;
      if (t > 20000) begin
        chk(0, "R4", "grant never finished", t, 20000);
        n = 3;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) begin
      m_en[i] = 0; m_bo[i] = 0; m_sf[i] = 0; m_df[i] = 0;
      m_cnt[i] = 0; m_exp[i] = 0; m_sz[i] = 0; m_src[i] = 0; m_dst[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(xfer_valid == 0, "R9", "reset valid", xfer_valid, 0);
    chk(ch_done == 0, "R8", "reset done", ch_done, 0);
    @(posedge clk); #1 rst_n = 1;

    // R9: disabled channel with both lines high
    arm(1, 0, 0, 0, 0, 2, 3, 5, 32'h1000, 32'h2000);
    req(4'b0010, 4'b0010, 10); wait_idle();

    // R1: single request only, one item
    rdy_pct = 60;
    arm(2, 1, 0, 0, 0, 2, 3, 5, 32'h100, 32'h200);
    req(4'b0100, 4'b0000, 1); wait_idle();

    // R2: burst of 2^2 out of 10
    arm(1, 1, 0, 0, 0, 1, 2, 10, 32'h3000, 32'h4000);
    req(4'b0000, 4'b0010, 1); wait_idle();

    // R3: both lines on channel 0 -> burst of 2
    arm(0, 1, 0, 0, 0, 0, 1, 9, 32'h10, 32'h20);
    req(4'b0001, 4'b0001, 1); wait_idle();

    // R4: channel 0 asks during a channel 3 burst
    arm(3, 1, 0, 0, 0, 2, 3, 8, 32'h500, 32'h600);
    req(4'b0000, 4'b1000, 1);
    repeat (3) @(posedge clk);
    req(4'b0001, 4'b0000, 3); wait_idle();

    // R5: burst-only channel ignores single, then accepts burst
    arm(1, 1, 1, 0, 0, 0, 1, 6, 32'h700, 32'h800);
    req(4'b0010, 4'b0000, 10); wait_idle();
    req(4'b0010, 4'b0010, 1); wait_idle();

    // R7/R8: fixed source, count runs out, later requests ignored
    arm(2, 1, 0, 1, 0, 0, 0, 3, 32'hABC, 32'h900);
    req(4'b0100, 4'b0000, 20); wait_idle();
    req(4'b0100, 4'b0100, 8); wait_idle();
    // R8: re-arm
    wr(2, 2'd2, 32'd2); m_cnt[2] = 2;
    wr(2, 2'd3, {20'd0, 4'd4, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1});
    m_en[2] = 1; m_df[2] = 1; m_sf[2] = 0; m_sz[2] = 1; m_exp[2] = 4;
    req(4'b0000, 4'b0100, 1); wait_idle();

    // R2: exponent above 10 clamps to 1024 items
    rdy_pct = 90;
    arm(0, 1, 0, 0, 0, 2, 13, 1100, 32'h0, 32'h8000_0000);
    req(4'b0000, 4'b0001, 1); wait_idle();
    req(4'b0000, 4'b0001, 1); wait_idle();

    // constrained random
    for (int r = 0; r < 250; r++) begin
      rdy_pct = 30 + ($urandom % 71);
      for (int c = 0; c < NCH; c++)
        arm(c, ($urandom % 5) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
            ($urandom % 4) == 0, $urandom % 4, $urandom % 16, $urandom % 40,
            $urandom, $urandom);
      req(4'($urandom), 4'($urandom), 1 + ($urandom % 30));
      wait_idle();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule